// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI/LO Result Pair

This block performs 32-bit multiplication and division for a simple in-order integer core. The core sends one request per cycle. A request names an R-type function code and carries two operands. The four arithmetic codes start a shift-and-add multiply or a restoring divide. Each runs for a fixed 32 cycles on operand magnitudes. A sign fix-up is applied when the result is written into a dedicated pair of result registers, HI and LO.

The two move codes read back HI or LO on `rd_data`. While an operation is running, `busy` is high. A read that arrives during that time raises `stall`, so the core holds the read until the unit is idle. Arithmetic requests that arrive while `busy` is high are dropped. Division by zero finishes like any other divide, leaves fixed values in HI and LO, and raises no trap.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset, `busy` and `stall` are low, and both HI and LO read as zero.
- R2: Function code 0x19 (unsigned multiply) writes the 64-bit unsigned product of A and B, with the upper 32 bits in HI and the lower 32 bits in LO.
- R3: Function code 0x18 (signed multiply) treats A and B as two's complement and writes the 64-bit signed product, upper half in HI and lower half in LO.
- R4: Function code 0x1B (unsigned divide) writes A/B into LO and A mod B into HI, both unsigned.
- R5: Function code 0x1A (signed divide) truncates the quotient toward zero into LO. The remainder goes into HI and carries the sign of the dividend. The case -2^31 / -1 gives LO = 0x80000000 and HI = 0.
- R6: Division by zero completes normally. Unsigned: LO = 0xFFFFFFFF and HI = A. Signed: HI = A, and LO = 1 when A is negative, otherwise 0xFFFFFFFF.
- R7: An arithmetic request accepted at a clock edge sets `busy` high from that edge for exactly 32 cycles. HI and LO take their new values at the edge where `busy` falls.
- R8: An arithmetic request presented while `busy` is high is ignored. It neither restarts nor lengthens the running operation, and it does not change that operation's results.
- R9: Read requests use code 0x10 for HI and 0x12 for LO. A read presented while `busy` is high raises `stall` in that same cycle. When idle, `rd_data` returns HI for 0x10 and LO for 0x12, and `stall` stays low.
- R10: A request whose function code is none of the six listed codes starts nothing and leaves HI and LO unchanged.
- R11: HI and LO keep their values whenever the unit is idle, and while an operation runs until its completion edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_funct | input | 6 | R-type function code of the request |
| req_a | input | 32 | First operand (multiplicand or dividend) |
| req_b | input | 32 | Second operand (multiplier or divisor) |
| busy | output | 1 | An operation is in progress |
| stall | output | 1 | A read arrived while busy and must be retried |
| rd_data | output | 32 | HI or LO, selected by the read code |

## Verification
The embedded properties check several rules on every cycle:
- an accepted request always leads to `busy`;
- `stall` never appears while the unit is idle;
- HI and LO never move outside a completion edge;
- an unsigned divide by zero always ends with LO all ones.

The arithmetic itself can only be shown by the bench's scenarios. These include signed and unsigned products and quotients, the extreme operand values, the exact 32-cycle duration, and the dropping of requests that arrive mid-operation. A behavioural model computes the expected HI, LO, `busy` and `stall` with plain integer arithmetic, and it is compared with the outputs every cycle.

// File: rtl/muldiv_hilo.sv
module muldiv_hilo #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic [5:0]   req_funct,
  input  logic [W-1:0] req_a,
  input  logic [W-1:0] req_b,
  output logic         busy,
  output logic         stall,
  output logic [W-1:0] rd_data
);
  localparam int CW = $clog2(W);
  localparam logic [5:0] F_MFHI = 6'h10;
  localparam logic [5:0] F_MFLO = 6'h12;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt;
  logic          div_op, neg_q, neg_r;
  logic [W-1:0]  acc_hi, acc_lo, opb, hi, lo;

  wire is_arith = (req_funct[5:2] == 4'b0110);
  wire is_read  = (req_funct == F_MFHI) || (req_funct == F_MFLO);
  wire sgn      = ~req_funct[0];
  wire start    = req_valid && is_arith && !busy;
  wire a_neg    = sgn & req_a[W-1];
  wire b_neg    = sgn & req_b[W-1];
  wire [W-1:0] a_mag = a_neg ? -req_a : req_a;
  wire [W-1:0] b_mag = b_neg ? -req_b : req_b;
  wire last     = busy && (cnt == LAST);

  wire [W:0] msum = {1'b0, acc_hi} + {1'b0, (acc_lo[0] ? opb : '0)};
  wire [W:0] dsh  = {acc_hi, acc_lo[W-1]};
  wire [W:0] dif  = dsh - {1'b0, opb};

  logic [W-1:0] nxt_hi, nxt_lo;
  always_comb begin
    if (div_op) begin
      nxt_hi = dif[W] ? dsh[W-1:0] : dif[W-1:0];
      nxt_lo = {acc_lo[W-2:0], ~dif[W]};
    end else begin
      nxt_hi = msum[W:1];
      nxt_lo = {msum[0], acc_lo[W-1:1]};
    end
  end

  wire [2*W-1:0] prod   = {nxt_hi, nxt_lo};
  wire [2*W-1:0] prod_s = neg_q ? -prod : prod;
  wire [W-1:0]   quo_s  = neg_q ? -nxt_lo : nxt_lo;
  wire [W-1:0]   rem_s  = neg_r ? -nxt_hi : nxt_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      div_op <= 1'b0;
      neg_q  <= 1'b0;
      neg_r  <= 1'b0;
      acc_hi <= '0;
      acc_lo <= '0;
      opb    <= '0;
      hi     <= '0;
      lo     <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      cnt    <= '0;
      div_op <= req_funct[1];
      neg_q  <= a_neg ^ b_neg;
      neg_r  <= a_neg;
      acc_hi <= '0;
      acc_lo <= a_mag;
      opb    <= b_mag;
    end else if (busy) begin
      cnt    <= cnt + 1'b1;
      acc_hi <= nxt_hi;
      acc_lo <= nxt_lo;
      if (last) begin
        busy <= 1'b0;
        if (div_op) begin
          hi <= rem_s;
          lo <= quo_s;
        end else begin
          hi <= prod_s[2*W-1:W];
          lo <= prod_s[W-1:0];
        end
      end
    end
  end

  assign stall   = req_valid && is_read && busy;
  assign rd_data = (req_funct == F_MFHI) ? hi : lo;

  assert_start_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_arith && !busy) |=> busy);
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(hi) && $stable(lo)));
  assert_run_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != LAST) |=> ($stable(hi) && $stable(lo)));
  assert_stall_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> busy);
  assert_div0_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (last && div_op && opb == '0 && !neg_q) |=> (lo == '1));
endmodule

// File: tb/muldiv_hilo_tb.sv
module muldiv_hilo_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [5:0] req_funct = 6'h0;
  logic [31:0] req_a = '0, req_b = '0;
  logic busy, stall;
  logic [31:0] rd_data;

  muldiv_hilo u_dut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_funct(req_funct),
    .req_a(req_a), .req_b(req_b), .busy(busy), .stall(stall), .rd_data(rd_data));

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  string cur_req = "R1";
  bit mbusy = 0;
  int mcnt = 0;
  logic [31:0] mhi = 0, mlo = 0, phi = 0, plo = 0;

  function automatic logic [63:0] ref_op(logic [5:0] f, logic [31:0] a, logic [31:0] b);
    longint sa, sb, q, r;
    logic [63:0] p;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (f)
      6'h19: p = {32'h0, a} * {32'h0, b};
      6'h18: p = 64'(sa * sb);
      6'h1B: p = (b == 0) ? {a, 32'hFFFFFFFF} : {a % b, a / b};
      default: begin
        if (b == 0) p = {a, (a[31] ? 32'h1 : 32'hFFFFFFFF)};
        else begin
          q = sa / sb;
          r = sa % sb;
          p = {r[31:0], q[31:0]};
        end
      end
    endcase
    return p;
  endfunction

  function automatic bit arith(logic [5:0] f);
    return f == 6'h18 || f == 6'h19 || f == 6'h1A || f == 6'h1B;
  endfunction

  always @(posedge clk) begin
    logic [63:0] p;
    if (!rst_n) begin
      mbusy = 0; mcnt = 0; mhi = 0; mlo = 0;
    end else if (mbusy) begin
      mcnt--;
      if (mcnt == 0) begin
        mbusy = 0; mhi = phi; mlo = plo;
      end
    end else if (req_valid && arith(req_funct)) begin
      p = ref_op(req_funct, req_a, req_b);
      phi = p[63:32]; plo = p[31:0];
      mbusy = 1; mcnt = 32;
    end
  end

  task automatic check(bit ok, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit rd, exp_stall;
    if (rst_n) begin
      rd = req_valid && (req_funct == 6'h10 || req_funct == 6'h12);
      exp_stall = rd && mbusy;
      check(busy === mbusy, "busy", 32'(busy), 32'(mbusy));
      check(stall === exp_stall, "stall", 32'(stall), 32'(exp_stall));
      if (rd && !mbusy)
        check(rd_data === ((req_funct == 6'h10) ? mhi : mlo), "rd_data", rd_data,
              (req_funct == 6'h10) ? mhi : mlo);
    end
  end

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  task automatic drive(bit v, logic [5:0] f, logic [31:0] a, logic [31:0] b);
    @(posedge clk); #1;
    req_valid = v; req_funct = f; req_a = a; req_b = b;
  endtask

  task automatic read_back;
    drive(1, 6'h10, 0, 0);
    drive(1, 6'h12, 0, 0);
    drive(0, 0, 0, 0);
  endtask

  task automatic run_op(string tag, logic [5:0] f, logic [31:0] a, logic [31:0] b);
    cur_req = tag;
    drive(1, f, a, b);
    repeat (33) drive(1, 6'h10, 0, 0);
    read_back();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cur_req = "R1";
    @(negedge clk);
    check(busy === 1'b0, "reset busy", 32'(busy), 0);
    read_back();

    run_op("R2", 6'h19, 32'hFFFFFFFF, 32'hFFFFFFFF);
    run_op("R2", 6'h19, 32'h12345678, 32'h9ABCDEF0);
    run_op("R3", 6'h18, 32'hFFFFFFFF, 32'h00000005);
    run_op("R3", 6'h18, 32'h80000000, 32'h80000000);
    run_op("R3", 6'h18, 32'h7FFFFFFF, 32'h80000000);
    run_op("R4", 6'h1B, 32'hFFFFFFFF, 32'h00000007);
    run_op("R4", 6'h1B, 32'h00000003, 32'h80000000);
    run_op("R5", 6'h1A, 32'hFFFFFFF9, 32'h00000002);
    run_op("R5", 6'h1A, 32'h00000007, 32'hFFFFFFFE);
    run_op("R5", 6'h1A, 32'h80000000, 32'hFFFFFFFF);
    run_op("R6", 6'h1B, 32'h00001234, 32'h0);
    run_op("R6", 6'h1A, 32'hFFFFFF00, 32'h0);
    run_op("R6", 6'h1A, 32'h00000055, 32'h0);

    cur_req = "R7";
    drive(1, 6'h19, 32'd6, 32'd7);
    drive(0, 0, 0, 0);
    repeat (31) drive(0, 0, 0, 0);
    @(negedge clk);
    check(busy === 1'b1, "busy at cycle 32", 32'(busy), 1);
    repeat (2) drive(0, 0, 0, 0);
    read_back();

    cur_req = "R8";
    drive(1, 6'h19, 32'd1000, 32'd3);
    repeat (20) drive(1, 6'h1B, 32'hDEAD, 32'd5);
    repeat (13) drive(1, 6'h12, 0, 0);
    read_back();

    cur_req = "R10";
    drive(1, 6'h20, 32'h55, 32'h66);
    drive(1, 6'h00, 32'h77, 32'h88);
    drive(0, 0, 0, 0);
    @(negedge clk);
    check(busy === 1'b0, "no start", 32'(busy), 0);
    read_back();

    cur_req = "R11";
    for (int i = 0; i < 16; i++) begin
      logic [5:0] f;
      f = 6'h18 + 6'(i % 4);
      run_op("R11", f, $urandom, (i % 5 == 0) ? 32'($urandom % 9) : $urandom);
      repeat (3) drive(0, 0, 0, 0);
      read_back();
    end

    report();
  end
endmodule